// File: doc/BRIEF.md
# Unified Translation Buffer with Staged Entry Load

This block holds the translation entries of a memory management unit in one fully associative table of 64 entries. Software fills the table indirectly. It first writes a control word, an entry-high word, an entry-low word and an entry-attribute word through a small write port. A one-cycle load command then copies the staged words into the table slot named by the replace-index field of the control word.

The lookup side is purely combinational from the stored entries. A 32-bit virtual address and an 8-bit address-space identifier go in. The block returns the matching slot number, the translated physical address and the entry's protection, cache and space attributes. It also reports whether the lookup missed or hit more than one entry.

Each entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), so every slot compares a different number of address bits. Overlapping entries are not resolved by priority; they are reported as an error.

Top module: `utlb_core`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports a miss.
- R2: A load writes the slot whose number is in bits 15:10 of the control word (write select 0). A hit returns that slot number in `lk_index` with bit 6 clear.
- R3: The entry-high word (write select 1) supplies the address-space identifier from bits 7:0 and the virtual page number from bits 31:10.
- R4: The entry-low word (write select 2) supplies valid at bit 8, protection at bits 6:5, cacheable at bit 3, dirty at bit 2, shared at bit 1, write-through at bit 0, and the physical page number at bits 28:10. On a hit these appear on `lk_prot`, `lk_cache`, `lk_dirty`, `lk_shared` and `lk_wt`.
- R5: The page size code is {low bit 7, low bit 4}: 00 gives 1 KB, 01 gives 4 KB, 10 gives 64 KB and 11 gives 1 MB. An entry covers the range from its base to base plus size minus one. The base is the page number shifted left by 10 with the bits below the page size cleared.
- R6: On a hit, `lk_pa` is the physical page base (page number shifted left by 10, bits below the page size cleared) with the address bits below the page size inserted. Bits 31:29 are zero.
- R7: A slot whose valid bit is clear never matches.
- R8: A slot matches only if its identifier equals `lk_asid`, unless its shared bit is set.
- R9: When two or more slots match, `lk_multi` is 1, `lk_hit` is 0, and `lk_index` is 7'h7F.
- R10: When no slot matches, `lk_miss` is 1 and `lk_index` is 7'h7F. In both non-hit cases `lk_pa` and all attribute outputs are 0. Exactly one of hit, miss and multi is 1.
- R11: The attribute word (write select 3) keeps only its low 4 bits. Bits 2:0 give `lk_space` and bit 3 gives `lk_tcb`.
- R12: A load takes one clock, and a lookup in the next cycle sees the new entry. A staging write in the same cycle as a load takes effect only after that load, which uses the earlier staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Staging write strobe |
| ctl_sel | input | 2 | Staging target: 0 control, 1 entry-high, 2 entry-low, 3 attribute |
| ctl_wdata | input | 32 | Staging write data |
| load_req | input | 1 | Copy staged words into the slot named by the control word |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Exactly one slot matched |
| lk_miss | output | 1 | No slot matched |
| lk_multi | output | 1 | More than one slot matched |
| lk_index | output | 7 | Matching slot, or 7'h7F when not a hit |
| lk_pa | output | 32 | Translated physical address |
| lk_prot | output | 2 | Protection code |
| lk_cache | output | 1 | Cacheable flag |
| lk_dirty | output | 1 | Dirty flag |
| lk_wt | output | 1 | Write-through flag |
| lk_shared | output | 1 | Shared flag |
| lk_space | output | 3 | Space attribute |
| lk_tcb | output | 1 | Timing-control bit |

## Verification
Directed addresses probe each page size at its first byte, its last byte and the bytes just outside. This separates a correct size mask from one that is off by a bit. A large page with a small page loaded inside it separates the multiple-hit error from a priority pick. The same page is looked up with equal and unequal identifiers, with and without the shared bit, and with the valid bit clear, to isolate each matching condition. Random loads into random slots, mixed with lookups aimed inside loaded pages and with random stray addresses, are compared against a range-based model. That model catches wrong slot encoding, wrong physical composition and stale data after a load.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef struct packed {
    logic [21:0] vpn;
    logic [7:0]  asid;
    logic        v;
    logic [18:0] ppn;
    logic [1:0]  sz;
    logic        sh;
    logic        c;
    logic        d;
    logic        wt;
    logic [1:0]  pr;
    logic [2:0]  sa;
    logic        tc;
  } tlb_ent_t;

  // Offset mask: ones below the page size selected by the code.
  function automatic logic [31:0] offs_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   offs_mask = 32'h0000_03FF;
      2'b01:   offs_mask = 32'h0000_0FFF;
      2'b10:   offs_mask = 32'h0000_FFFF;
      default: offs_mask = 32'h000F_FFFF;
    endcase
  endfunction

  function automatic logic ent_match(input tlb_ent_t e, input logic [31:0] va,
                                     input logic [7:0] asid);
    logic [31:0] m;
    m = offs_mask(e.sz);
    ent_match = e.v && (e.sh || (e.asid == asid)) &&
                ((va & ~m) == ({e.vpn, 10'b0} & ~m));
  endfunction

  function automatic logic [31:0] ent_pa(input tlb_ent_t e, input logic [31:0] va);
    logic [31:0] m;
    m = offs_mask(e.sz);
    ent_pa = ({3'b000, e.ppn, 10'b0} & ~m) | (va & m);
  endfunction

endpackage

// File: rtl/utlb_stage.sv
module utlb_stage
  import utlb_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [31:0]      wdata,
  output logic [IDX_W-1:0] urc,
  output tlb_ent_t         staged
);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_HI  = 2'd1;
  localparam logic [1:0] SEL_LO  = 2'd2;
  localparam logic [1:0] SEL_AS  = 2'd3;

  logic unused_bit9;
  assign unused_bit9 = wdata[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urc    <= '0;
      staged <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTL: urc <= wdata[IDX_LSB +: IDX_W];
        SEL_HI: begin
          staged.vpn  <= wdata[31:10];
          staged.asid <= wdata[7:0];
        end
        SEL_LO: begin
          staged.ppn <= wdata[28:10];
          staged.v   <= wdata[8];
          staged.sz  <= {wdata[7], wdata[4]};
          staged.pr  <= wdata[6:5];
          staged.c   <= wdata[3];
          staged.d   <= wdata[2];
          staged.sh  <= wdata[1];
          staged.wt  <= wdata[0];
        end
        default: begin
          staged.tc <= wdata[3];
          staged.sa <= wdata[2:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/utlb_store.sv
module utlb_store
  import utlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  tlb_ent_t         load_ent,
  output tlb_ent_t         ents [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel_this;
    assign sel_this = load && (load_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)        ents[g] <= '0;
      else if (sel_this) ents[g] <= load_ent;
    end
  end
endmodule

// File: rtl/utlb_lookup.sv
module utlb_lookup
  import utlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  tlb_ent_t         ents [N],
  input  logic [31:0]      va,
  input  logic [7:0]       asid,
  output logic [N-1:0]     match_vec,
  output logic             hit,
  output logic             miss,
  output logic             multi,
  output logic [IDX_W:0]   index,
  output tlb_ent_t         hit_ent,
  output logic [31:0]      pa
);
  localparam int EW = $bits(tlb_ent_t);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = ent_match(ents[g], va, asid);
  end

  logic             any_m, many_m;
  logic [IDX_W-1:0] idx_or;
  logic [EW-1:0]    ent_or;

  always_comb begin
    any_m  = 1'b0;
    many_m = 1'b0;
    idx_or = '0;
    ent_or = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        many_m = many_m | any_m;
        any_m  = 1'b1;
        idx_or = idx_or | IDX_W'(i);
        ent_or = ent_or | ents[i];
      end
    end
  end

  assign hit     = any_m && !many_m;
  assign miss    = !any_m;
  assign multi   = many_m;
  assign index   = hit ? {1'b0, idx_or} : '1;
  assign hit_ent = hit ? tlb_ent_t'(ent_or) : '0;
  assign pa      = hit ? ent_pa(tlb_ent_t'(ent_or), va) : '0;
endmodule

// File: rtl/utlb_core.sv
module utlb_core
  import utlb_pkg::*;
#(
  parameter int N       = 64,
  parameter int IDX_LSB = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr_en,
  input  logic [1:0]  ctl_sel,
  input  logic [31:0] ctl_wdata,
  input  logic        load_req,
  input  logic [31:0] lk_va,
  input  logic [7:0]  lk_asid,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_multi,
  output logic [6:0]  lk_index,
  output logic [31:0] lk_pa,
  output logic [1:0]  lk_prot,
  output logic        lk_cache,
  output logic        lk_dirty,
  output logic        lk_wt,
  output logic        lk_shared,
  output logic [2:0]  lk_space,
  output logic        lk_tcb
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] urc;
  tlb_ent_t         staged;
  tlb_ent_t         ents [N];
  logic [N-1:0]     match_vec;
  tlb_ent_t         hit_ent;
  logic [IDX_W:0]   index_w;

  utlb_stage #(.IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .sel(ctl_sel),
    .wdata(ctl_wdata), .urc(urc), .staged(staged)
  );

  utlb_store #(.N(N), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load_req), .load_idx(urc),
    .load_ent(staged), .ents(ents)
  );

  utlb_lookup #(.N(N), .IDX_W(IDX_W)) u_lookup (
    .ents(ents), .va(lk_va), .asid(lk_asid), .match_vec(match_vec),
    .hit(lk_hit), .miss(lk_miss), .multi(lk_multi), .index(index_w),
    .hit_ent(hit_ent), .pa(lk_pa)
  );

  assign lk_index  = 7'(index_w);
  assign lk_prot   = hit_ent.pr;
  assign lk_cache  = hit_ent.c;
  assign lk_dirty  = hit_ent.d;
  assign lk_wt     = hit_ent.wt;
  assign lk_shared = hit_ent.sh;
  assign lk_space  = hit_ent.sa;
  assign lk_tcb    = hit_ent.tc;
endmodule

// File: rtl/utlb_check.sv
module utlb_check #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] match_vec,
  input logic         lk_hit,
  input logic         lk_miss,
  input logic         lk_multi,
  input logic [6:0]   lk_index,
  input logic [31:0]  lk_pa,
  input logic [1:0]   lk_prot
);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_multi}) == 1);

  a_r9_multi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(match_vec) > 1) |-> (lk_multi && !lk_hit && lk_index == 7'h7F));

  a_r10_miss_index: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec == '0) |-> (lk_miss && lk_index == 7'h7F && lk_pa == 32'h0 && lk_prot == 2'b00));

  a_r2_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (!lk_index[6] && match_vec[lk_index[5:0]]));

  a_r6_pa_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[31:29] == 3'b000));
endmodule

bind utlb_core utlb_check #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_vec(match_vec), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_index(lk_index),
  .lk_pa(lk_pa), .lk_prot(lk_prot)
);

// File: tb/utlb_core_test.sv
module utlb_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [1:0]  ctl_sel = 2'd0;
  logic [31:0] ctl_wdata = 32'h0;
  logic        load_req = 1'b0;
  logic [31:0] lk_va = 32'h0;
  logic [7:0]  lk_asid = 8'h0;
  logic        lk_hit, lk_miss, lk_multi;
  logic [6:0]  lk_index;
  logic [31:0] lk_pa;
  logic [1:0]  lk_prot;
  logic        lk_cache, lk_dirty, lk_wt, lk_shared, lk_tcb;
  logic [2:0]  lk_space;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  utlb_core uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .load_req(load_req), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_index(lk_index),
    .lk_pa(lk_pa), .lk_prot(lk_prot), .lk_cache(lk_cache), .lk_dirty(lk_dirty),
    .lk_wt(lk_wt), .lk_shared(lk_shared), .lk_space(lk_space), .lk_tcb(lk_tcb)
  );

  always #10 clk = ~clk;

  // Reference model: staged words and per-slot words.
  logic [31:0] m_ctl = 0, m_hi = 0, m_lo = 0, m_as = 0;
  logic [31:0] s_hi [64];
  logic [31:0] s_lo [64];
  logic [31:0] s_as [64];

  function automatic logic [31:0] page_bytes(input logic [31:0] lo);
    case ({lo[7], lo[4]})
      2'b00:   return 32'd1 << 10;
      2'b01:   return 32'd1 << 12;
      2'b10:   return 32'd1 << 16;
      default: return 32'd1 << 20;
    endcase
  endfunction

  function automatic logic [31:0] page_base(input logic [31:0] hi, input logic [31:0] lo);
    return {hi[31:10], 10'b0} & ~(page_bytes(lo) - 1);
  endfunction

  function automatic logic slot_covers(input int k, input logic [31:0] va, input logic [7:0] asid);
    logic [31:0] b;
    b = page_base(s_hi[k], s_lo[k]);
    return s_lo[k][8] && (s_lo[k][1] || s_hi[k][7:0] == asid) &&
           va >= b && va <= b + (page_bytes(s_lo[k]) - 1);
  endfunction

  function automatic logic [51:0] expect_out(input logic [31:0] va, input logic [7:0] asid);
    int cnt = 0;
    int k0 = 0;
    logic [31:0] pbase, pa;
    for (int k = 0; k < 64; k++) if (slot_covers(k, va, asid)) begin cnt++; k0 = k; end
    if (cnt == 0) return {3'b010, 7'h7F, 42'h0};
    if (cnt > 1)  return {3'b001, 7'h7F, 42'h0};
    pbase = {3'b000, s_lo[k0][28:10], 10'b0} & ~(page_bytes(s_lo[k0]) - 1);
    pa = pbase + (va - page_base(s_hi[k0], s_lo[k0]));
    return {3'b100, 7'(k0), pa, s_lo[k0][6:5], s_lo[k0][3], s_lo[k0][2], s_lo[k0][0],
            s_lo[k0][1], s_as[k0][2:0], s_as[k0][3]};
  endfunction

  task automatic check_lookup(input logic [31:0] va, input logic [7:0] asid, input string req);
    logic [51:0] got, exp;
    lk_va = va;
    lk_asid = asid;
    #2;
    got = {lk_hit, lk_miss, lk_multi, lk_index, lk_pa, lk_prot, lk_cache, lk_dirty,
           lk_wt, lk_shared, lk_space, lk_tcb};
    exp = expect_out(va, asid);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s va=%h asid=%h actual=%h expected=%h", req, va, asid, got, exp);
    end
  endtask

  task automatic stage_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    ctl_sel = sel; ctl_wdata = d; ctl_wr_en = 1'b1;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    case (sel)
      2'd0: m_ctl = d;
      2'd1: m_hi = d;
      2'd2: m_lo = d;
      default: m_as = d & 32'hF;
    endcase
  endtask

  task automatic do_load();
    @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    s_hi[m_ctl[15:10]] = m_hi;
    s_lo[m_ctl[15:10]] = m_lo;
    s_as[m_ctl[15:10]] = m_as;
  endtask

  task automatic put_entry(input int idx, input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] as_w);
    stage_write(2'd0, 32'(idx) << 10);
    stage_write(2'd1, hi);
    stage_write(2'd2, lo);
    stage_write(2'd3, as_w);
    do_load();
  endtask

  // Low word: valid, size code, physical page, attrs.
  function automatic logic [31:0] mk_lo(input logic v, input logic [1:0] sz,
                                        input logic [31:0] pbase, input logic [4:0] attrs);
    return (pbase & 32'h1FFF_FC00) | (32'(v) << 8) | (32'(sz[1]) << 7) | (32'(sz[0]) << 4)
           | (32'(attrs[4:3]) << 5) | 32'(attrs[2:0]) | 32'h0;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd2024);
    for (int k = 0; k < 64; k++) begin s_hi[k] = 0; s_lo[k] = 0; s_as[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    check_lookup(32'h0000_0000, 8'h00, "R1");
    check_lookup(32'h8123_4567, 8'h3C, "R1");

    // R2 R3 R4: load slot 37, 4K page, attributes
    put_entry(37, 32'h1234_5000 | 32'h5A, mk_lo(1'b1, 2'b01, 32'h0ABC_D000, 5'b10_1_0_1) | 32'h4,
              32'h6);
    check_lookup(32'h1234_5ABC, 8'h5A, "R2 R3 R4");
    check_lookup(32'h1234_5ABC, 8'h5B, "R3");

    // R5 R6: each size at its edges
    for (int sz = 0; sz < 4; sz++) begin
      logic [31:0] b, sb;
      b = 32'h4000_0000 + (32'(sz) << 24);
      put_entry(10 + sz, b | 32'h0000_0400 | 32'h11, mk_lo(1'b1, 2'(sz), 32'h1100_0000 + (32'(sz) << 22), 5'b01_0_0_0),
                32'h9);
      sb = page_base(b | 32'h400, mk_lo(1'b1, 2'(sz), 0, 0));
      check_lookup(sb, 8'h11, "R5");
      check_lookup(sb + page_bytes(mk_lo(1'b1, 2'(sz), 0, 0)) - 1, 8'h11, "R5 R6");
      check_lookup(sb + page_bytes(mk_lo(1'b1, 2'(sz), 0, 0)), 8'h11, "R5");
      check_lookup(sb - 1, 8'h11, "R5");
      check_lookup(sb + 32'h2A5, 8'h11, "R6");
    end

    // R7: valid clear
    put_entry(20, 32'h5000_0011, mk_lo(1'b0, 2'b11, 32'h0, 5'b0), 32'h0);
    check_lookup(32'h5000_0100, 8'h11, "R7");

    // R8: identifier and shared bit
    put_entry(21, 32'h6000_0011, mk_lo(1'b1, 2'b10, 32'h0200_0000, 5'b00_0_0_0), 32'h1);
    check_lookup(32'h6000_1234, 8'h11, "R8");
    check_lookup(32'h6000_1234, 8'h22, "R8");
    put_entry(22, 32'h6100_0033, mk_lo(1'b1, 2'b10, 32'h0300_0000, 5'b00_0_1_0), 32'h2);
    check_lookup(32'h6100_0010, 8'h99, "R8");

    // R9: large page with small page inside
    put_entry(30, 32'h7000_0001, mk_lo(1'b1, 2'b11, 32'h0400_0000, 5'b11_0_0_0), 32'h0);
    put_entry(31, 32'h7004_2001, mk_lo(1'b1, 2'b01, 32'h0500_0000, 5'b0), 32'h0);
    check_lookup(32'h7004_2010, 8'h01, "R9");
    check_lookup(32'h7008_0000, 8'h01, "R9");

    // R11: attribute word upper bits dropped
    put_entry(40, 32'h7800_0007, mk_lo(1'b1, 2'b00, 32'h0600_0000, 5'b0), 32'hFFFF_FFF5);
    check_lookup(32'h7800_0001, 8'h07, "R11");
    put_entry(40, 32'h7800_0007, mk_lo(1'b1, 2'b00, 32'h0600_0000, 5'b0), 32'h8000_000A);
    check_lookup(32'h7800_0001, 8'h07, "R11");

    // R12: staging write in the load cycle; load uses old low word
    stage_write(2'd0, 32'd50 << 10);
    stage_write(2'd1, 32'h7900_0008);
    stage_write(2'd2, mk_lo(1'b1, 2'b01, 32'h0700_0000, 5'b0));
    @(negedge clk);
    load_req = 1'b1; ctl_wr_en = 1'b1; ctl_sel = 2'd2; ctl_wdata = 32'h0;
    @(negedge clk);
    load_req = 1'b0; ctl_wr_en = 1'b0;
    s_hi[50] = m_hi; s_lo[50] = m_lo; s_as[50] = m_as;
    m_lo = 32'h0;
    check_lookup(32'h7900_0FFF, 8'h08, "R12");
    do_load();
    check_lookup(32'h7900_0FFF, 8'h08, "R12");

    // R10: stray addresses
    for (int n = 0; n < 10; n++) check_lookup($urandom | 32'h8000_0000, 8'($urandom), "R10");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 4);
      if (r == 0) begin
        put_entry(int'($urandom % 64), $urandom,
                  ($urandom & 32'h1FFF_FCFF) | (($urandom % 5 != 0) ? 32'h100 : 32'h0), $urandom);
      end else if (r == 1) begin
        check_lookup($urandom, 8'($urandom), "R10");
      end else begin
        int k;
        logic [31:0] b;
        k = int'($urandom % 64);
        b = page_base(s_hi[k], s_lo[k]);
        check_lookup(b + ($urandom & (page_bytes(s_lo[k]) - 1)),
                     ($urandom % 4 == 0) ? 8'($urandom) : s_hi[k][7:0], "R5 R6 R2");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule